// File: doc/BRIEF.md
# Per-Pin GPIO Interrupt Sensitivity Unit

This unit watches a bank of general-purpose input pins and turns each one into an interrupt request bit. Every pin is brought into the system clock domain through a two-stage synchronizer. Three configuration bits per pin then decide how the pin raises a request:

- an inversion bit picks the active level or the active edge;
- a mode bit picks level sensitivity or edge sensitivity;
- a dual-edge bit, which counts only in edge mode, makes every transition count whatever the inversion bit says.

A direction register marks pins that are driven as outputs. Those pins never raise a request.

Configuration is loaded through a plain write strobe with a 3-bit register address. In edge mode a detected transition is captured in a per-pin sticky bit. That bit stays set until software writes a one to the matching bit of the acknowledge address. The per-pin request vector is an output, and so is a single combined request that can drive one interrupt line.

Top module: `gpio_irq_sense`

## Requirements
- R1: After reset every configuration register and every sticky bit is zero, so each pin acts as an active-high level input (request equals the synchronized pin value).
- R2: A level-mode pin (mode bit 0) with inversion bit 0 requests while its synchronized value is 1. The request appears two clock edges after the pin changes and is not held after the pin returns.
- R3: A level-mode pin with inversion bit 1 requests while its synchronized value is 0.
- R4: An edge-mode pin (mode bit 1) with dual-edge bit 0 latches a request on a rising transition when its inversion bit is 0, and on a falling transition when its inversion bit is 1. The opposite transition does not set it.
- R5: An edge-mode pin with dual-edge bit 1 latches a request on both rising and falling transitions, regardless of its inversion bit.
- R6: The dual-edge bit has no effect on a level-mode pin.
- R7: A pin whose direction bit is 1 (output) never requests, whatever its inversion, mode and dual-edge bits are.
- R8: A pin pulse that lasts one clock period, and so is sampled by a single clock edge, still sets the sticky bit of an edge-mode pin.
- R9: A write of data D to the acknowledge address clears the sticky bits where D is 1 and leaves the other bits unchanged. If a new qualifying edge is detected in the same cycle as the acknowledge, the bit stays set.
- R10: The combined request output is the OR of all bits of the per-pin request vector.
- R11: A pin whose mode bit is 0 holds no sticky event. Turning edge mode off and then on again starts the pin with no pending request.
- R12: The register addresses are: 0 direction, 1 inversion, 2 mode, 3 dual-edge, 4 acknowledge. A write to any other address changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address |
| wrData | input | 16 | Write data, one bit per pin |
| pinIn | input | 16 | Asynchronous pin inputs |
| irqVec | output | 16 | Per-pin interrupt requests |
| irqAny | output | 1 | OR of all per-pin requests |

## Verification
Each pin carries its own eight-way configuration, so a fault in the synchronizer, the previous-value register or one sticky bit shows up as a single wrong bit of `irqVec`. In level mode that bit is wrong two edges after the pin moves. In edge mode it is wrong three edges after the transition. A sticky bit stuck at one shows up as a request that survives the next acknowledge. A lost edge shows up as a missing request after the single-cycle pulse test. A fault in how acknowledge and a new edge are ordered shows only when both happen in the same cycle, so the bench lines the two up on exactly that edge.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int CfgAddrW = 3;

  localparam logic [CfgAddrW-1:0] AddrDir  = 3'd0;
  localparam logic [CfgAddrW-1:0] AddrInv  = 3'd1;
  localparam logic [CfgAddrW-1:0] AddrMode = 3'd2;
  localparam logic [CfgAddrW-1:0] AddrDual = 3'd3;
  localparam logic [CfgAddrW-1:0] AddrAck  = 3'd4;

  typedef struct packed {
    logic loadDir;
    logic loadInv;
    logic loadMode;
    logic loadDual;
    logic ackHit;
  } cfgStrobe_t;

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int Width  = 16,
  parameter int Stages = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [Width-1:0] din,
  output logic [Width-1:0] dout
);

  logic [Width-1:0] stage [Stages];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < Stages; k++) stage[k] <= '0;
    end else begin
      stage[0] <= din;
      for (int k = 1; k < Stages; k++) stage[k] <= stage[k-1];
    end
  end

  assign dout = stage[Stages-1];

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NumPins = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [CfgAddrW-1:0] wrAddr,
  input  logic [NumPins-1:0]  wrData,
  output cfgStrobe_t          strobe,
  output logic [NumPins-1:0]  dirOut,
  output logic [NumPins-1:0]  invPol,
  output logic [NumPins-1:0]  edgeMode,
  output logic [NumPins-1:0]  dualEdge
);

  // Address decode into one-hot strobes (R12)
  always_comb begin
    strobe = '0;
    if (wrEn) begin
      unique case (wrAddr)
        AddrDir:  strobe.loadDir  = 1'b1;
        AddrInv:  strobe.loadInv  = 1'b1;
        AddrMode: strobe.loadMode = 1'b1;
        AddrDual: strobe.loadDual = 1'b1;
        AddrAck:  strobe.ackHit   = 1'b1;
        default:  strobe = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirOut   <= '0;
      invPol   <= '0;
      edgeMode <= '0;
      dualEdge <= '0;
    end else begin
      if (strobe.loadDir)  dirOut   <= wrData;
      if (strobe.loadInv)  invPol   <= wrData;
      if (strobe.loadMode) edgeMode <= wrData;
      if (strobe.loadDual) dualEdge <= wrData;
    end
  end

  // R12: configuration only moves on a write strobe
  a_r12_cfg_hold: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable({dirOut, invPol, edgeMode, dualEdge}));

endmodule

// File: rtl/gpio_irq_datapath.sv
module gpio_irq_datapath
  import gpio_irq_pkg::*;
#(
  parameter int NumPins    = 16,
  parameter int SyncStages = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NumPins-1:0] pinIn,
  input  logic [NumPins-1:0] dirOut,
  input  logic [NumPins-1:0] invPol,
  input  logic [NumPins-1:0] edgeMode,
  input  logic [NumPins-1:0] dualEdge,
  input  cfgStrobe_t         strobe,
  input  logic [NumPins-1:0] wrData,
  output logic [NumPins-1:0] irqVec
);

  logic [NumPins-1:0] pinSync;
  logic [NumPins-1:0] pinPrev;
  logic [NumPins-1:0] riseDet;
  logic [NumPins-1:0] fallDet;
  logic [NumPins-1:0] edgeHit;
  logic [NumPins-1:0] ackVec;
  logic [NumPins-1:0] sticky;
  logic [NumPins-1:0] levelAct;

  gpio_irq_sync #(.Width(NumPins), .Stages(SyncStages)) uSync (
    .clk  (clk),
    .rstN (rstN),
    .din  (pinIn),
    .dout (pinSync)
  );

  always_ff @(posedge clk) begin
    if (!rstN) pinPrev <= '0;
    else       pinPrev <= pinSync;
  end

  assign riseDet  = pinSync & ~pinPrev;
  assign fallDet  = ~pinSync & pinPrev;
  assign levelAct = pinSync ^ invPol;
  assign ackVec   = strobe.ackHit ? wrData : '0;

  for (genvar i = 0; i < NumPins; i++) begin : gPin
    logic chosen;
    always_comb begin
      if (dualEdge[i]) chosen = riseDet[i] | fallDet[i];
      else if (invPol[i]) chosen = fallDet[i];
      else chosen = riseDet[i];
    end
    assign edgeHit[i] = chosen & edgeMode[i] & ~dirOut[i];
    assign irqVec[i]  = ~dirOut[i] & (edgeMode[i] ? sticky[i] : levelAct[i]);
  end

  // New edge beats acknowledge; level-mode pins keep nothing
  always_ff @(posedge clk) begin
    if (!rstN) sticky <= '0;
    else       sticky <= edgeMode & ((sticky & ~ackVec) | edgeHit);
  end

  // R8: any detected edge is held on the next cycle
  a_r8_edge_held: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((sticky & $past(edgeHit)) == $past(edgeHit)));

  // R9: acknowledged bits without a fresh edge are cleared
  a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ackHit |=> ((sticky & $past(ackVec & ~edgeHit)) == '0));

  // R4: a sticky bit only rises when an edge was qualified
  a_r4_set_by_edge: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((sticky & ~$past(sticky) & ~$past(edgeHit)) == '0));

  // R11: level-mode pins hold no event
  a_r11_level_empty: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((sticky & ~$past(edgeMode)) == '0));

endmodule

// File: rtl/gpio_irq_sense.sv
module gpio_irq_sense
  import gpio_irq_pkg::*;
#(
  parameter int NumPins    = 16,
  parameter int SyncStages = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [CfgAddrW-1:0] wrAddr,
  input  logic [NumPins-1:0]  wrData,
  input  logic [NumPins-1:0]  pinIn,
  output logic [NumPins-1:0]  irqVec,
  output logic                irqAny
);

  cfgStrobe_t         strobe;
  logic [NumPins-1:0] dirOut;
  logic [NumPins-1:0] invPol;
  logic [NumPins-1:0] edgeMode;
  logic [NumPins-1:0] dualEdge;

  gpio_irq_ctrl #(.NumPins(NumPins)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .strobe   (strobe),
    .dirOut   (dirOut),
    .invPol   (invPol),
    .edgeMode (edgeMode),
    .dualEdge (dualEdge)
  );

  gpio_irq_datapath #(.NumPins(NumPins), .SyncStages(SyncStages)) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .pinIn    (pinIn),
    .dirOut   (dirOut),
    .invPol   (invPol),
    .edgeMode (edgeMode),
    .dualEdge (dualEdge),
    .strobe   (strobe),
    .wrData   (wrData),
    .irqVec   (irqVec)
  );

  assign irqAny = |irqVec;

  // R7: output pins stay silent
  a_r7_output_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (irqVec & dirOut) == '0);

endmodule

// File: tb/tb_gpio_irq_sense.sv
module tb_gpio_irq_sense;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] pinIn = '0;
  logic [15:0] irqVec;
  logic        irqAny;

  int runCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  // Bench-side configuration and expected state
  logic [15:0] cDir = '0, cInv = '0, cMode = '0, cDual = '0;
  logic [15:0] mPins = '0, mSticky = '0;

  always #2.5 clk = ~clk;

  gpio_irq_sense dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .pinIn(pinIn), .irqVec(irqVec), .irqAny(irqAny)
  );

  function automatic logic [15:0] hitsOf(logic [15:0] a, logic [15:0] b);
    logic [15:0] r = ~a & b;
    logic [15:0] f = a & ~b;
    logic [15:0] pick = (cDual & (r | f)) | (~cDual & cInv & f) | (~cDual & ~cInv & r);
    return pick & cMode & ~cDir;
  endfunction

  function automatic logic [15:0] expVec();
    return ~cDir & ((cMode & mSticky) | (~cMode & (mPins ^ cInv)));
  endfunction

  task automatic check(string tag);
    logic [15:0] e = expVec();
    runCnt++;
    if (irqVec !== e) begin
      failCnt++;
      $display("FAIL %s irqVec actual=%h expected=%h", tag, irqVec, e);
    end
    runCnt++;
    if (irqAny !== (|e)) begin
      failCnt++;
      $display("FAIL R10 (%s) irqAny actual=%b expected=%b", tag, irqAny, |e);
    end
  endtask

  task automatic wrReg(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    case (a)
      3'd0: cDir = d;
      3'd1: cInv = d;
      3'd2: begin cMode = d; mSticky &= d; end
      3'd3: cDual = d;
      3'd4: mSticky &= ~d;
      default: ;
    endcase
    repeat (2) @(negedge clk);
  endtask

  task automatic applyPins(logic [15:0] b, string tag);
    @(negedge clk);
    pinIn = b;
    mSticky |= hitsOf(mPins, b);
    mPins = b;
    repeat (4) @(negedge clk);
    check(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", runCnt, failCnt);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset state");
    applyPins(16'hFFFF, "R1 R2 default active-high level");
    applyPins(16'h0000, "R2 level released");

    // Pin i gets config (i mod 8): bit0 inversion, bit1 mode, bit2 dual-edge
    wrReg(3'd1, 16'hAAAA);
    wrReg(3'd2, 16'hCCCC);
    wrReg(3'd3, 16'hF0F0);
    wrReg(3'd0, 16'hF000);
    check("R3 R6 R7 configured idle");
    // Unmapped addresses change nothing (R12)
    wrReg(3'd5, 16'hFFFF);
    wrReg(3'd7, 16'h5555);
    check("R12 unmapped write");

    begin
      logic [15:0] pats [8] = '{16'hFFFF, 16'h0000, 16'h5A5A, 16'hA5A5,
                                16'h0FF0, 16'hFFFF, 16'h1234, 16'h0000};
      for (int p = 0; p < 8; p++) begin
        wrReg(3'd4, 16'hFFFF);
        check("R9 full acknowledge");
        applyPins(pats[p], "R2 R3 R4 R5 R6 R7 pattern sweep");
      end
    end
    for (int k = 0; k < 16; k++) begin
      applyPins(16'h0001 << k, "R4 R5 walking one");
      applyPins(16'h0000, "R4 R5 walking one return");
    end

    // R8: one-cycle pulses in both directions
    wrReg(3'd4, 16'hFFFF);
    @(negedge clk);
    pinIn = 16'hFFFF;
    @(negedge clk);
    pinIn = 16'h0000;
    mSticky |= hitsOf(16'h0000, 16'hFFFF) | hitsOf(16'hFFFF, 16'h0000);
    repeat (4) @(negedge clk);
    check("R8 single-cycle high pulse");
    wrReg(3'd4, 16'hFFFF);
    applyPins(16'hFFFF, "R4 setup high");
    wrReg(3'd4, 16'hFFFF);
    @(negedge clk);
    pinIn = 16'h0000;
    @(negedge clk);
    pinIn = 16'hFFFF;
    mSticky |= hitsOf(16'hFFFF, 16'h0000) | hitsOf(16'h0000, 16'hFFFF);
    repeat (4) @(negedge clk);
    check("R8 single-cycle low pulse");

    // R9: partial acknowledge keeps the other bits
    wrReg(3'd4, 16'h00FF);
    check("R9 partial acknowledge");

    // R9: acknowledge on the same edge the new event is latched
    wrReg(3'd4, 16'hFFFF);
    @(negedge clk);
    pinIn = 16'h0000;
    @(negedge clk);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 3'd4; wrData = 16'hFFFF;
    @(negedge clk);
    wrEn = 1'b0;
    mSticky = hitsOf(16'hFFFF, 16'h0000);
    mPins = 16'h0000;
    repeat (3) @(negedge clk);
    check("R9 new edge wins over acknowledge");

    // R11: leaving edge mode drops events
    wrReg(3'd2, 16'h0000);
    check("R11 edge mode off");
    wrReg(3'd2, 16'hCCCC);
    check("R11 edge mode back on, no pending");

    // R7: outputs silent even with all pins active
    wrReg(3'd0, 16'hFFFF);
    applyPins(16'hFFFF, "R7 all outputs");
    applyPins(16'h0000, "R7 all outputs falling");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", runCnt, failCnt);
    $finish;
  end

endmodule